// File: doc/BRIEF.md
# Clock-Sampled Asynchronous SRAM Emulator

This block stands in for a byte-wide asynchronous static RAM inside a synchronous design. It can serve as an on-chip memory model or as a reference when checking a memory controller. On every clock edge it samples three active-low strobes, the address and the write byte: chip select `ce_ni`, output enable `oe_ni` and write strobe `we_ni`. From that sample it decodes one of four modes: standby, read, write or output-off. It then drives a read byte, a drive flag and a standby flag.

A write does not happen while the strobes are low. The write window is the span during which chip select and write strobe are both low. The address and data are captured on every sampled cycle inside that window. The bytes captured last are committed on the clock after the window is seen to close. The window may be closed by chip select, by the write strobe, or by both together. A change of address or data in the same sample that closes the window does not reach the array.

`ADDR_W = 15` with `DATA_W = 8` gives the 32K x 8 organisation. The default is a smaller array so that the default build stays light. The array has no reset, so its contents are unknown until they are written.

Top module: `sram_emu`

## Requirements
- R1: While chip select is sampled high, `standby_o` is 1 and `drive_o` is 0, whatever the levels of output enable and write strobe. No write window opens.
- R2: In the sample after chip select low, write strobe high and output enable low, `drive_o` is 1 and `rdata_o` holds the byte stored at the sampled address.
- R3: In the sample after chip select and write strobe are both low, `drive_o` is 0 and `standby_o` is 0, even with output enable low.
- R4: In the sample after chip select low with write strobe and output enable both high, `drive_o` is 0 and `standby_o` is 0.
- R5: When the write strobe rising closes the window, the address and data from the last sample inside the window are written. Values present in the closing sample are not used.
- R6: When chip select rising closes the window, the address and data from the last sample inside the window are written.
- R7: When chip select and write strobe rise in the same sample, the write is committed, and in that sample `drive_o` is 0 and `standby_o` is 1.
- R8: In a window spanning several samples with changing address, only the final address and data are written. Addresses presented earlier in the window keep their contents.
- R9: A read sampled in the cycle right after the closing sample already returns the newly written byte.
- R10: While `rst_ni` is low and right after it is released, `standby_o` is 1 and `drive_o` is 0.
- R11: Whenever `drive_o` is 0, `rdata_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write strobe, active low |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write byte |
| rdata_o | output | DATA_W | Read byte, zero when not driven |
| drive_o | output | 1 | High only in read mode |
| standby_o | output | 1 | High while chip select is sampled high |

## Verification
The assertions check on every cycle that the mode decode agrees with the previous sample of the strobes. They cover standby following chip select, the drive flag only after a read sample, no drive during a write window, and a zero read bus when not driving. They also check that a commit pulse never lasts two cycles. Only the bench scenarios can show which address and data reach the array: that the last in-window sample wins, that values arriving with the closing sample are ignored, that each of the three ways of ending a window commits, and that a read right after the closing sample sees the new byte.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READ    = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_QUIET   = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_emu_sampler.sv
module sram_emu_sampler #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ce_nq_o,
  output logic              oe_nq_o,
  output logic              we_nq_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] wdata_q_o
);
  // strobes reset to inactive so the block starts deselected
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_nq_o   <= 1'b1;
      oe_nq_o   <= 1'b1;
      we_nq_o   <= 1'b1;
      addr_q_o  <= '0;
      wdata_q_o <= '0;
    end else begin
      ce_nq_o   <= ce_ni;
      oe_nq_o   <= oe_ni;
      we_nq_o   <= we_ni;
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
  import sram_emu_pkg::*;
(
  input  logic       ce_nq_i,
  input  logic       oe_nq_i,
  input  logic       we_nq_i,
  output sram_mode_e mode_o
);
  always_comb begin
    if (ce_nq_i)       mode_o = MODE_STANDBY;
    else if (!we_nq_i) mode_o = MODE_WRITE;
    else if (!oe_nq_i) mode_o = MODE_READ;
    else               mode_o = MODE_QUIET;
  end
endmodule

// File: rtl/sram_emu_wctl.sv
module sram_emu_wctl
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sram_mode_e        mode_i,
  input  logic [ADDR_W-1:0] addr_q_i,
  input  logic [DATA_W-1:0] wdata_q_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic in_window;
  logic window_d;

  assign in_window = (mode_i == MODE_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      window_d   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      window_d <= in_window;
      if (in_window) begin
        mem_addr_o <= addr_q_i;
        mem_data_o <= wdata_q_i;
      end
    end
  end

  // window seen open last sample, closed now: commit the captured pair
  assign mem_we_o = window_d && !in_window;
endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

  // R5, R6: a closed window commits exactly once
  a_r5_single_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !we_i);
endmodule

// File: rtl/sram_emu.sv
module sram_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o,
  output logic              standby_o
);
  logic              ce_nq, oe_nq, we_nq;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  sram_mode_e        mode;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;
  logic [DATA_W-1:0] arr_rdata;

  sram_emu_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sampler (
    .clk_i, .rst_ni, .ce_ni, .oe_ni, .we_ni, .addr_i, .wdata_i,
    .ce_nq_o(ce_nq), .oe_nq_o(oe_nq), .we_nq_o(we_nq),
    .addr_q_o(addr_q), .wdata_q_o(wdata_q)
  );

  sram_emu_decode i_decode (
    .ce_nq_i(ce_nq), .oe_nq_i(oe_nq), .we_nq_i(we_nq), .mode_o(mode)
  );

  sram_emu_wctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wctl (
    .clk_i, .rst_ni, .mode_i(mode), .addr_q_i(addr_q), .wdata_q_i(wdata_q),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  sram_emu_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk_i, .rst_ni, .we_i(mem_we), .waddr_i(mem_addr), .wdata_i(mem_data),
    .raddr_i(addr_q), .rdata_o(arr_rdata)
  );

  assign drive_o   = (mode == MODE_READ);
  assign standby_o = (mode == MODE_STANDBY);
  assign rdata_o   = drive_o ? arr_rdata : '0;

  a_r1_standby_follows_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ce_ni) |-> (standby_o && !drive_o));
  a_r2_drive_only_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> $past(!ce_ni && we_ni && !oe_ni));
  a_r3_no_drive_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && !we_ni) |=> (!drive_o && !standby_o));
  a_r11_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (rdata_o == '0));
endmodule

// File: tb/test_sram_emu.sv
module test_sram_emu;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          drive, standby;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [DW-1:0] model [N];

  always #5 clk = ~clk;

  sram_emu #(.ADDR_W(AW), .DATA_W(DW)) i_sram_emu (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive),
    .standby_o(standby)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // drive one sample at negedge, return just after the sampling edge
  task automatic step(input logic c, input logic o, input logic w,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = a; wdata = d;
    @(posedge clk);
    #2;
  endtask

  // one-sample window; closing sample carries junk address/data
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit by_ce);
    step(1'b0, 1'b1, 1'b0, a, d);
    if (by_ce) step(1'b1, 1'b1, 1'b0, a ^ 4'h1, ~d);
    else       step(1'b0, 1'b1, 1'b1, a ^ 4'h1, ~d);
    model[a] = d;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a);
    step(1'b0, 1'b0, 1'b1, a, 8'h00);
    chk(req, {31'd0, drive}, 32'd1);
    chk(req, {24'd0, rdata}, {24'd0, model[a]});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10
    chk("R10 reset standby", {31'd0, standby}, 32'd1);
    chk("R10 reset drive", {31'd0, drive}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R10 post reset standby", {31'd0, standby}, 32'd1);

    // R5 sweep: strobe-ended writes, then read all
    for (int a = 0; a < N; a++) wr(a[AW-1:0], 8'(a * 37 + 5), 1'b0);
    for (int a = 0; a < N; a++) rd("R5 R2 strobe-ended sweep", a[AW-1:0]);
    // R6 sweep: select-ended writes
    for (int a = 0; a < N; a++) wr(a[AW-1:0], 8'(~(a * 13)), 1'b1);
    for (int a = N - 1; a >= 0; a--) rd("R6 R2 select-ended sweep", a[AW-1:0]);

    // R9: read immediately after the closing sample
    wr(4'd3, 8'hA5, 1'b0);
    rd("R9 read right after close", 4'd3);
    wr(4'd9, 8'h3C, 1'b1);
    rd("R9 read right after select close", 4'd9);

    // R3: window with output enable low
    step(1'b0, 1'b0, 1'b0, 4'd6, 8'h77);
    chk("R3 no drive", {31'd0, drive}, 32'd0);
    chk("R3 active", {31'd0, standby}, 32'd0);
    chk("R11 zero bus", {24'd0, rdata}, 32'd0);
    // R8: address moves inside the window
    step(1'b0, 1'b0, 1'b0, 4'd7, 8'h88);
    step(1'b0, 1'b0, 1'b0, 4'd8, 8'h99);
    step(1'b0, 1'b1, 1'b1, 4'd8, 8'h00);
    model[8] = 8'h99;
    rd("R8 final address written", 4'd8);
    rd("R8 earlier address untouched", 4'd6);
    rd("R8 earlier address untouched", 4'd7);

    // R7: both strobes rise together with output enable low
    step(1'b0, 1'b0, 1'b0, 4'd12, 8'h5A);
    step(1'b1, 1'b0, 1'b1, 4'd13, 8'hFF);
    chk("R7 standby", {31'd0, standby}, 32'd1);
    chk("R7 no drive", {31'd0, drive}, 32'd0);
    model[12] = 8'h5A;
    rd("R7 committed", 4'd12);
    rd("R7 junk address untouched", 4'd13);

    // R4: output-off mode
    step(1'b0, 1'b1, 1'b1, 4'd12, 8'h00);
    chk("R4 no drive", {31'd0, drive}, 32'd0);
    chk("R4 active", {31'd0, standby}, 32'd0);
    chk("R11 zero bus quiet", {24'd0, rdata}, 32'd0);

    // R1: strobes low under deselect open no window
    step(1'b1, 1'b0, 1'b0, 4'd2, 8'hEE);
    chk("R1 standby", {31'd0, standby}, 32'd1);
    chk("R1 no drive", {31'd0, drive}, 32'd0);
    step(1'b1, 1'b0, 1'b1, 4'd2, 8'hEE);
    step(1'b1, 1'b1, 1'b1, 4'd2, 8'hEE);
    rd("R1 no write under deselect", 4'd2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule